// File: doc/BRIEF.md
# Parallel Instruction Grouping Unit

This block sits in the pipeline stage between fetch/decode and operand read. Each cycle it looks at a window of up to four decoded instructions in program order. Every instruction carries its class (multiply-accumulate or ALU), two source register indices and one destination register index. The block decides how many instructions, counted from the oldest, may issue together in the next cycle on a machine with two MAC units and two ALUs.

The group stops at the first instruction that cannot join. That instruction may be invalid, it may have no free unit of its class, it may read a register that an older window slot writes (read-after-write), or it may write the same register as an older slot (write-after-write). The decision is registered. The registered group gives the size, a valid mask, a unit id for each slot, and bypass flags for each source. A source is flagged for bypass when it reads a result of the group that was issued just before. A combinational pop count tells the decode queue how many entries leave the window on this edge. A stall input freezes the registered group and forces the pop count to zero.

Top module: `igu_group`

## Requirements
- R1: The registered group size never exceeds the window depth of four. `grp_vld` bit k is 1 exactly when k < `grp_size`.
- R2: A group holds at most two MAC-class instructions (`win_mac`=1) and at most two ALU-class instructions (`win_mac`=0). A window instruction that would be a third of its class ends the group.
- R3: A slot whose source A or source B equals the destination of any older window slot is not issued, and it ends the group.
- R4: A slot whose destination equals the destination of any older window slot is not issued, and it ends the group.
- R5: Groups are contiguous from slot 0. The first slot that cannot be placed ends the group, and younger slots are not issued even when they are free of conflicts. An invalid slot also ends the group.
- R6: When slot 0 is invalid, the group size and the pop count are zero.
- R7: Each issued slot k gets a 2-bit unit id in `grp_unit[2k+1:2k]`. Bit 1 is the class (1 = MAC, 0 = ALU). Bit 0 is the number of older issued slots of the same class, so the first gets unit 0 and the second gets unit 1. Slots that are not issued read id 0. No two issued slots share an id.
- R8: `grp_byp_a[k]` (or `grp_byp_b[k]`) is 1 when slot k is issued and its source A (or B) equals the destination of any instruction in the group held in the output register when the new group was loaded. The flags are 0 for slots that are not issued.
- R9: When `stall` is low, `pop_cnt` equals the size of the group that is being computed. After the next clock edge, `grp_size` shows that value. When `stall` is high, `pop_cnt` is 0.
- R10: While `stall` is high, all registered outputs keep their values.
- R11: Reset empties the registered group (size, valid, unit and bypass all zero). No bypass is flagged against destinations issued before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall | input | 1 | Holds the registered group and blocks pop |
| win_vld | input | 4 | Slot valid, bit 0 oldest |
| win_mac | input | 4 | Slot class, 1 = MAC, 0 = ALU |
| win_src_a | input | 16 | Source A index for each slot, 4 bits per slot |
| win_src_b | input | 16 | Source B index for each slot, 4 bits per slot |
| win_dst | input | 16 | Destination index for each slot, 4 bits per slot |
| pop_cnt | output | 3 | Entries taken from the window this edge |
| grp_size | output | 3 | Registered group size |
| grp_vld | output | 4 | Registered issued-slot mask |
| grp_unit | output | 8 | Unit id for each slot, 2 bits per slot |
| grp_byp_a | output | 4 | Source A bypass flag for each slot |
| grp_byp_b | output | 4 | Source B bypass flag for each slot |

## Verification
The bench sweeps every class pattern against every valid prefix length. A wrong resource count would issue a third MAC or ALU, or would split two of them without cause. For each pair of older and younger slots, it places a dependency through source A, through source B and through the destination alone. A design that compared only one source, or only adjacent slots, would issue a dependent instruction. Windows with a gap and windows with a blocked slot followed by free slots expose a design that skips ahead instead of stopping. Stall holds and a mid-run reset catch bypass flags raised against a stale or cleared previous group.

// File: rtl/igu_pkg.sv
package igu_pkg;
   typedef enum logic {CLS_ALU = 1'b0, CLS_MAC = 1'b1} igu_cls_e;

   function automatic int igu_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int igu_idx_w(input int mac_units, input int alu_units);
      int m;
      m = igu_max(mac_units, alu_units);
      return (m <= 2) ? 1 : $clog2(m);
   endfunction
endpackage

// File: rtl/igu_hazard.sv
module igu_hazard #(
   parameter int SLOTS = 4,
   parameter int REG_W = 4
) (
   input  logic [SLOTS*REG_W-1:0] src_a,
   input  logic [SLOTS*REG_W-1:0] src_b,
   input  logic [SLOTS*REG_W-1:0] dst,
   output logic [SLOTS-1:0]       raw,
   output logic [SLOTS-1:0]       waw
);
   // pair-wise compare of every younger slot against every older slot
   for (genvar k = 0; k < SLOTS; k++) begin : g_young
      logic [REG_W-1:0] sa_k, sb_k, d_k;
      assign sa_k = src_a[k*REG_W +: REG_W];
      assign sb_k = src_b[k*REG_W +: REG_W];
      assign d_k  = dst[k*REG_W +: REG_W];
      if (k == 0) begin : g_first
         assign raw[k] = 1'b0;
         assign waw[k] = 1'b0;
      end else begin : g_rest
         logic [k-1:0] raw_hit, waw_hit;
         for (genvar j = 0; j < k; j++) begin : g_old
            logic [REG_W-1:0] d_j;
            assign d_j        = dst[j*REG_W +: REG_W];
            assign raw_hit[j] = (sa_k == d_j) || (sb_k == d_j);
            assign waw_hit[j] = (d_k == d_j);
         end
         assign raw[k] = |raw_hit;
         assign waw[k] = |waw_hit;
      end
   end
endmodule

// File: rtl/igu_resource.sv
module igu_resource #(
   parameter int SLOTS     = 4,
   parameter int MAC_UNITS = 2,
   parameter int ALU_UNITS = 2,
   parameter int IDX_W     = 1
) (
   input  logic [SLOTS-1:0]       is_mac,
   output logic [SLOTS-1:0]       over,
   output logic [SLOTS*IDX_W-1:0] ord
);
   localparam int CNT_W = $clog2(SLOTS + 1);

   for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      logic [CNT_W-1:0] n_mac, n_alu;
      always_comb begin
         n_mac = '0;
         for (int j = 0; j < k; j++) begin
            n_mac = n_mac + CNT_W'(is_mac[j]);
         end
         n_alu = CNT_W'(k) - n_mac;
      end
      assign over[k] = is_mac[k] ? (int'(n_mac) >= MAC_UNITS)
                                 : (int'(n_alu) >= ALU_UNITS);
      assign ord[k*IDX_W +: IDX_W] = is_mac[k] ? IDX_W'(n_mac) : IDX_W'(n_alu);
   end
endmodule

// File: rtl/igu_bypass.sv
module igu_bypass #(
   parameter int SLOTS         = 4,
   parameter int REG_W         = 4,
   parameter bit BYP_LAST_ONLY = 1'b0
) (
   input  logic [SLOTS*REG_W-1:0] src_a,
   input  logic [SLOTS*REG_W-1:0] src_b,
   input  logic [SLOTS*REG_W-1:0] prev_dst,
   input  logic [SLOTS-1:0]       prev_vld,
   output logic [SLOTS-1:0]       byp_a,
   output logic [SLOTS-1:0]       byp_b
);
   logic [SLOTS-1:0] prod;

   // choose which producers of the previous group may forward
   if (BYP_LAST_ONLY) begin : g_last
      for (genvar j = 0; j < SLOTS; j++) begin : g_tail
         if (j == SLOTS - 1) begin : g_end
            assign prod[j] = prev_vld[j];
         end else begin : g_mid
            assign prod[j] = prev_vld[j] & ~prev_vld[j+1];
         end
      end
   end else begin : g_all
      assign prod = prev_vld;
   end

   for (genvar k = 0; k < SLOTS; k++) begin : g_cons
      logic [SLOTS-1:0] hit_a, hit_b;
      for (genvar j = 0; j < SLOTS; j++) begin : g_prod
         assign hit_a[j] = prod[j] && (src_a[k*REG_W +: REG_W] == prev_dst[j*REG_W +: REG_W]);
         assign hit_b[j] = prod[j] && (src_b[k*REG_W +: REG_W] == prev_dst[j*REG_W +: REG_W]);
      end
      assign byp_a[k] = |hit_a;
      assign byp_b[k] = |hit_b;
   end
endmodule

// File: rtl/igu_group.sv
module igu_group
   import igu_pkg::*;
#(
   parameter int SLOTS         = 4,
   parameter int REG_W         = 4,
   parameter int MAC_UNITS     = 2,
   parameter int ALU_UNITS     = 2,
   parameter bit BYP_LAST_ONLY = 1'b0,
   localparam int CNT_W        = $clog2(SLOTS + 1),
   localparam int IDX_W        = igu_idx_w(MAC_UNITS, ALU_UNITS),
   localparam int UID_W        = IDX_W + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   stall,
   input  logic [SLOTS-1:0]       win_vld,
   input  logic [SLOTS-1:0]       win_mac,
   input  logic [SLOTS*REG_W-1:0] win_src_a,
   input  logic [SLOTS*REG_W-1:0] win_src_b,
   input  logic [SLOTS*REG_W-1:0] win_dst,
   output logic [CNT_W-1:0]       pop_cnt,
   output logic [CNT_W-1:0]       grp_size,
   output logic [SLOTS-1:0]       grp_vld,
   output logic [SLOTS*UID_W-1:0] grp_unit,
   output logic [SLOTS-1:0]       grp_byp_a,
   output logic [SLOTS-1:0]       grp_byp_b
);
   // elaboration-time parameter checks
   if (SLOTS < 1 || SLOTS > 8) begin : g_bad_slots
      $error("igu_group: SLOTS must lie in 1..8");
   end
   if (REG_W < 1 || REG_W > 8) begin : g_bad_regw
      $error("igu_group: REG_W must lie in 1..8");
   end
   if (MAC_UNITS < 1 || ALU_UNITS < 1) begin : g_bad_units
      $error("igu_group: at least one unit of each class is required");
   end
   if ((1 << IDX_W) < igu_max(MAC_UNITS, ALU_UNITS)) begin : g_bad_idx
      $error("igu_group: unit index field too narrow");
   end

   logic [SLOTS-1:0]       raw, waw, over, byp_a, byp_b;
   logic [SLOTS*IDX_W-1:0] ord;
   logic [SLOTS-1:0]       fit, take;
   logic [CNT_W-1:0]       size_d;
   logic [SLOTS*UID_W-1:0] unit_d;
   logic [SLOTS*REG_W-1:0] dst_q;

   igu_hazard #(.SLOTS(SLOTS), .REG_W(REG_W)) u_hazard (
      .src_a (win_src_a),
      .src_b (win_src_b),
      .dst   (win_dst),
      .raw   (raw),
      .waw   (waw)
   );

   igu_resource #(
      .SLOTS(SLOTS), .MAC_UNITS(MAC_UNITS), .ALU_UNITS(ALU_UNITS), .IDX_W(IDX_W)
   ) u_resource (
      .is_mac (win_mac),
      .over   (over),
      .ord    (ord)
   );

   igu_bypass #(
      .SLOTS(SLOTS), .REG_W(REG_W), .BYP_LAST_ONLY(BYP_LAST_ONLY)
   ) u_bypass (
      .src_a    (win_src_a),
      .src_b    (win_src_b),
      .prev_dst (dst_q),
      .prev_vld (grp_vld),
      .byp_a    (byp_a),
      .byp_b    (byp_b)
   );

   // in-order prefix: a slot issues only if every older slot issued
   assign fit = win_vld & ~raw & ~waw & ~over;
   for (genvar k = 0; k < SLOTS; k++) begin : g_take
      if (k == 0) begin : g_head
         assign take[k] = fit[k];
      end else begin : g_chain
         assign take[k] = take[k-1] & fit[k];
      end
      assign unit_d[k*UID_W +: UID_W] =
         take[k] ? {win_mac[k], ord[k*IDX_W +: IDX_W]} : '0;
   end

   always_comb begin
      size_d = '0;
      for (int k = 0; k < SLOTS; k++) begin
         size_d = size_d + CNT_W'(take[k]);
      end
   end

   assign pop_cnt = stall ? '0 : size_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grp_size  <= '0;
         grp_vld   <= '0;
         grp_unit  <= '0;
         grp_byp_a <= '0;
         grp_byp_b <= '0;
         dst_q     <= '0;
      end else if (!stall) begin
         grp_size  <= size_d;
         grp_vld   <= take;
         grp_unit  <= unit_d;
         grp_byp_a <= byp_a & take;
         grp_byp_b <= byp_b & take;
         dst_q     <= win_dst;
      end
   end
endmodule

// File: rtl/igu_chk.sv
module igu_chk #(
   parameter int SLOTS     = 4,
   parameter int REG_W     = 4,
   parameter int MAC_UNITS = 2,
   parameter int ALU_UNITS = 2,
   parameter int CNT_W     = 3,
   parameter int UID_W     = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   stall,
   input logic [SLOTS-1:0]       win_vld,
   input logic [SLOTS-1:0]       win_mac,
   input logic [SLOTS*REG_W-1:0] win_src_a,
   input logic [SLOTS*REG_W-1:0] win_src_b,
   input logic [SLOTS*REG_W-1:0] win_dst,
   input logic [CNT_W-1:0]       pop_cnt,
   input logic [CNT_W-1:0]       grp_size,
   input logic [SLOTS-1:0]       grp_vld,
   input logic [SLOTS*UID_W-1:0] grp_unit,
   input logic [SLOTS-1:0]       grp_byp_a,
   input logic [SLOTS-1:0]       grp_byp_b
);
   logic [SLOTS-1:0]       s_mac;
   logic [SLOTS*REG_W-1:0] s_sa, s_sb, s_dst;
   logic [SLOTS-1:0]       want_mask;
   logic                   raw_bad, waw_bad, dup_bad;

   // copy of the window that the registered group was taken from
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s_mac <= '0; s_sa <= '0; s_sb <= '0; s_dst <= '0;
      end else if (!stall) begin
         s_mac <= win_mac; s_sa <= win_src_a; s_sb <= win_src_b; s_dst <= win_dst;
      end
   end

   always_comb begin
      raw_bad = 1'b0;
      waw_bad = 1'b0;
      dup_bad = 1'b0;
      for (int k = 0; k < SLOTS; k++) begin
         want_mask[k] = (k < int'(grp_size));
         for (int j = 0; j < k; j++) begin
            if (grp_vld[k] && grp_vld[j]) begin
               if (s_sa[k*REG_W +: REG_W] == s_dst[j*REG_W +: REG_W] ||
                   s_sb[k*REG_W +: REG_W] == s_dst[j*REG_W +: REG_W]) raw_bad = 1'b1;
               if (s_dst[k*REG_W +: REG_W] == s_dst[j*REG_W +: REG_W]) waw_bad = 1'b1;
               if (grp_unit[k*UID_W +: UID_W] == grp_unit[j*UID_W +: UID_W]) dup_bad = 1'b1;
            end
         end
      end
   end

   // R1
   size_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(grp_size) <= SLOTS) && (grp_vld == want_mask));
   // R2
   unit_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(grp_vld & s_mac) <= MAC_UNITS) &&
      ($countones(grp_vld & ~s_mac) <= ALU_UNITS));
   // R3
   raw_free_chk: assert property (@(posedge clk) disable iff (!rst_n) !raw_bad);
   // R4
   waw_free_chk: assert property (@(posedge clk) disable iff (!rst_n) !waw_bad);
   // R6
   empty_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !win_vld[0] |-> (pop_cnt == '0));
   // R7
   unit_unique_chk: assert property (@(posedge clk) disable iff (!rst_n) !dup_bad);
   // R8
   byp_issued_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((grp_byp_a | grp_byp_b) & ~grp_vld) == '0);
   // R9
   pop_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stall |=> (grp_size == $past(pop_cnt)));
   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> ($stable(grp_size) && $stable(grp_vld) && $stable(grp_unit) &&
                 $stable(grp_byp_a) && $stable(grp_byp_b)));
   // R11
   reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (grp_size == '0 && grp_vld == '0));
endmodule

bind igu_group igu_chk #(
   .SLOTS(SLOTS), .REG_W(REG_W), .MAC_UNITS(MAC_UNITS), .ALU_UNITS(ALU_UNITS),
   .CNT_W(CNT_W), .UID_W(UID_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .stall(stall),
   .win_vld(win_vld), .win_mac(win_mac),
   .win_src_a(win_src_a), .win_src_b(win_src_b), .win_dst(win_dst),
   .pop_cnt(pop_cnt), .grp_size(grp_size), .grp_vld(grp_vld),
   .grp_unit(grp_unit), .grp_byp_a(grp_byp_a), .grp_byp_b(grp_byp_b)
);

// File: tb/tb_igu_group.sv
module tb_igu_group;
   localparam int S = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        stall = 1'b0;
   logic [3:0]  d_vld = '0, d_mac = '0;
   logic [15:0] d_sa = '0, d_sb = '0, d_dst = '0;
   logic [2:0]  pop_cnt, grp_size;
   logic [3:0]  grp_vld, grp_byp_a, grp_byp_b;
   logic [7:0]  grp_unit;

   int n_chk = 0;
   int n_fail = 0;

   // model state and expectations
   logic [3:0]  p_vld = '0;
   logic [15:0] p_dst = '0;
   int          e_size;
   logic [3:0]  e_vld, e_ba, e_bb;
   logic [7:0]  e_unit;
   logic [31:0] rng = 32'h1234_5678;

   always #2 clk = ~clk;

   igu_group dut (
      .clk(clk), .rst_n(rst_n), .stall(stall),
      .win_vld(d_vld), .win_mac(d_mac),
      .win_src_a(d_sa), .win_src_b(d_sb), .win_dst(d_dst),
      .pop_cnt(pop_cnt), .grp_size(grp_size), .grp_vld(grp_vld),
      .grp_unit(grp_unit), .grp_byp_a(grp_byp_a), .grp_byp_b(grp_byp_b)
   );

   function automatic logic [3:0] fld(input logic [15:0] v, input int k);
      return v[k*4 +: 4];
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic next_rng();
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
   endtask

   // expected group from the requirements
   task automatic model_eval();
      int mc, ac;
      bit stop;
      e_size = 0; e_vld = '0; e_unit = '0; e_ba = '0; e_bb = '0;
      mc = 0; ac = 0; stop = 1'b0;
      for (int k = 0; k < S; k++) begin
         if (!stop) begin
            if (!d_vld[k]) stop = 1'b1;
            else if (d_mac[k] ? (mc >= 2) : (ac >= 2)) stop = 1'b1;
            else begin
               for (int j = 0; j < k; j++) begin
                  if (fld(d_sa, k) == fld(d_dst, j) || fld(d_sb, k) == fld(d_dst, j) ||
                      fld(d_dst, k) == fld(d_dst, j)) stop = 1'b1;
               end
            end
            if (!stop) begin
               e_vld[k] = 1'b1;
               e_size++;
               if (d_mac[k]) begin
                  e_unit[k*2 +: 2] = {1'b1, mc[0]};
                  mc++;
               end else begin
                  e_unit[k*2 +: 2] = {1'b0, ac[0]};
                  ac++;
               end
               for (int j = 0; j < S; j++) begin
                  if (p_vld[j] && fld(p_dst, j) == fld(d_sa, k)) e_ba[k] = 1'b1;
                  if (p_vld[j] && fld(p_dst, j) == fld(d_sb, k)) e_bb[k] = 1'b1;
               end
            end
         end
      end
   endtask

   // apply the current d_* window for one unstalled cycle
   task automatic run_win(input string tag);
      @(negedge clk);
      stall = 1'b0;
      #1;
      model_eval();
      chk({"R9 pop ", tag}, pop_cnt, e_size);
      @(posedge clk);
      #1;
      chk({tag, " size"}, grp_size, e_size);
      chk("R1 valid mask", grp_vld, e_vld);
      chk("R7 unit id", grp_unit, e_unit);
      chk("R8 bypass A", grp_byp_a, e_ba);
      chk("R8 bypass B", grp_byp_b, e_bb);
      p_vld = e_vld;
      p_dst = d_dst;
   endtask

   task automatic set_plain(input logic [3:0] vld, input logic [3:0] mac);
      d_vld = vld; d_mac = mac;
      d_dst = 16'h3210;
      d_sa  = 16'hBA98;
      d_sb  = 16'hFEDC;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin : main
      // R11: reset state
      repeat (2) @(posedge clk);
      #1;
      chk("R11 reset size", grp_size, 0);
      chk("R11 reset valid", grp_vld, 0);
      chk("R11 reset unit", grp_unit, 0);
      chk("R11 reset bypass", {grp_byp_a, grp_byp_b}, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2 / R5 / R6: every class pattern against every prefix length
      for (int m = 0; m < 16; m++) begin
         for (int n = 0; n <= 4; n++) begin
            set_plain(4'((1 << n) - 1), 4'(m));
            run_win(n == 0 ? "R6 empty" : "R2 classes");
         end
      end

      // R3 / R4: every older/younger pair, each dependency kind
      for (int y = 1; y < S; y++) begin
         for (int o = 0; o < y; o++) begin
            for (int kind = 0; kind < 3; kind++) begin
               set_plain(4'hF, 4'b0101);
               if (kind == 0) d_sa[y*4 +: 4] = fld(d_dst, o);
               if (kind == 1) d_sb[y*4 +: 4] = fld(d_dst, o);
               if (kind == 2) d_dst[y*4 +: 4] = fld(d_dst, o);
               run_win(kind == 2 ? "R4 waw" : "R3 raw");
               chk(kind == 2 ? "R4 stop slot" : "R3 stop slot", grp_size, y);
            end
         end
      end

      // R5: gap and blocked slot followed by free slots
      set_plain(4'b1011, 4'b0000);
      run_win("R5 gap");
      chk("R5 gap size", grp_size, 2);
      set_plain(4'hF, 4'b1000);
      d_sa[4 +: 4] = 4'h0;
      run_win("R5 blocked");
      chk("R5 blocked size", grp_size, 1);

      // R8: directed bypass from a full previous group
      set_plain(4'hF, 4'b0101);
      d_dst = 16'h4321;
      run_win("R8 producer");
      set_plain(4'hF, 4'b0101);
      d_sa[0 +: 4] = 4'h3;
      d_sb[4 +: 4] = 4'h1;
      run_win("R8 consumer");
      chk("R8 directed A", grp_byp_a, 4'b0001);
      chk("R8 directed B", grp_byp_b, 4'b0010);

      // R10 / R9: stall holds the group and blocks pop
      set_plain(4'b0111, 4'b0011);
      run_win("R10 before stall");
      for (int c = 0; c < 3; c++) begin
         @(negedge clk);
         stall = 1'b1;
         d_vld = 4'hF; d_mac = 4'(c); d_dst = 16'h89AB; d_sa = 16'h0123;
         #1;
         chk("R9 stalled pop", pop_cnt, 0);
         @(posedge clk);
         #1;
         chk("R10 held size", grp_size, e_size);
         chk("R10 held unit", grp_unit, e_unit);
         chk("R10 held valid", grp_vld, e_vld);
      end
      set_plain(4'hF, 4'b0110);
      d_sa = 16'h0000;
      run_win("R10 after stall");

      // R11: mid-run reset drops bypass producers
      set_plain(4'hF, 4'b0101);
      run_win("R11 pre reset");
      @(negedge clk);
      rst_n = 1'b0;
      @(posedge clk);
      #1;
      chk("R11 mid reset size", grp_size, 0);
      @(negedge clk);
      rst_n = 1'b1;
      p_vld = '0;
      set_plain(4'hF, 4'b0101);
      d_sa = 16'h3210;
      d_dst = 16'h7654;
      run_win("R11 post reset");
      chk("R11 no stale bypass", grp_byp_a, 0);

      // R3 / R4 / R8: pseudo-random windows with narrow register range
      for (int i = 0; i < 400; i++) begin
         next_rng(); d_vld = rng[3:0] | rng[7:4]; d_mac = rng[11:8];
         next_rng(); d_sa  = rng[15:0] & 16'h7777;
         next_rng(); d_sb  = rng[15:0] & 16'h7777;
         next_rng(); d_dst = rng[15:0] & 16'h7777;
         run_win("R3 random");
      end

      summary();
      $finish;
   end
endmodule